// File: doc/BRIEF.md
# Pipelined 16-bit Accumulator Microcontroller

This core is a small 16-bit processor for housekeeping tasks inside a larger FPGA design. All arithmetic goes through a single accumulator. The local variables sit in the same synchronous data RAM as ordinary data, so there is no separate register file. Instructions come from a second synchronous RAM. A program is loaded into that RAM through a write port while the core is held in reset.

The pipeline has two stages, each built around one synchronous memory read. The first stage fetches and decodes the instruction, and it presents the data-RAM read address. The second stage takes the data-RAM word, runs the ALU, and then writes either the accumulator or the data RAM, or performs an I/O transfer. With this split the core completes one instruction per clock without a forwarding network. The one exception is a store followed at once by a read of the same word, which is served by a bypass inside the data RAM wrapper. A taken branch discards the single instruction already fetched behind it.

Every instruction is 16 bits wide: an 8-bit opcode in bits 15:8 and an 8-bit argument in bits 7:0. I/O devices are reached only through dedicated port instructions that carry an 8-bit port number.

Top module: `tacc_core`

## Requirements
- R1: Reset is active-low and asynchronous. While reset is asserted, the accumulator reads 0 and both I/O strobes are low. After reset is released, the instruction at address 0 is the first to execute, and its I/O strobe is high during the cycle that follows the second rising edge.
- R2: The immediate ALU opcodes are 0x10 add, 0x11 subtract, 0x12 and, 0x13 or, 0x14 xor and 0x15 load. Each one combines the accumulator with the zero-extended 8-bit argument and puts the 16-bit result back into the accumulator, wrapping modulo 2^16.
- R3: Opcodes 0x20 to 0x25 perform the same six operations, but the operand is the data-RAM word at the address given in the argument. Opcode 0x30 stores the accumulator to the data-RAM word at the argument address.
- R4: When a store is followed directly by an instruction that reads the same data-RAM address, the reading instruction sees the newly stored value.
- R5: Straight-line code completes one instruction per clock. Two consecutive output instructions therefore strobe on consecutive cycles.
- R6: Opcode 0x50 is an unconditional branch to its own address plus the sign-extended 8-bit argument. A taken branch cancels the instruction behind it, so execution resumes at the target two cycles after the branch executes.
- R7: Opcodes 0x51, 0x52 and 0x53 branch when the accumulator is zero, nonzero, or has bit 15 set, respectively. A branch that is not taken costs no extra cycle.
- R8: Opcode 0x40 asserts io_wr for one cycle, with io_addr equal to the argument and io_wdata equal to the accumulator. Opcode 0x41 asserts io_rd with io_addr equal to the argument and loads io_rdata into the accumulator. The two strobes are never high together.
- R9: Opcode 0x60 copies the accumulator into a pointer register. Opcode 0x61 loads the data-RAM word at the pointer address, and opcode 0x62 stores the accumulator there. Opcode 0x61 placed directly after 0x60 uses the new pointer.
- R10: Opcode 0x16 (and 0x26) shifts the accumulator right by one bit, inserting a zero at bit 15 and ignoring the argument.
- R11: Any other opcode, including 0x17, 0x31 and 0xFF, changes neither the accumulator nor the data RAM and raises no I/O strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction RAM write enable |
| prog_addr | input | PC_W | Instruction RAM write address |
| prog_data | input | 16 | Instruction word to write |
| io_addr | output | 8 | Port number of the current I/O access, 0 when idle |
| io_rd | output | 1 | Input strobe |
| io_wr | output | 1 | Output strobe |
| io_wdata | output | 16 | Output data (accumulator value) |
| io_rdata | input | 16 | Input data, sampled while io_rd is high |
| acc_out | output | 16 | Current accumulator value |

## Verification
Several properties are checked on every cycle by the assertions:
- the two I/O strobes are mutually exclusive;
- the fetch address advances by one when no branch is taken;
- the fetch address lands on the branch target when a branch is taken;
- the slot behind a taken branch is cancelled;
- a same-address store-then-read returns the stored word;
- the accumulator holds its value whenever the execute stage does not write it.

Some results can only be shown by the directed programs, because they depend on operand values and instruction ordering:
- the numerical results of each ALU operation;
- the zero-fill of the right shift;
- conditional branches resolving on zero, nonzero and sign;
- backward-branch loops;
- pointer accesses that follow a pointer update at once;
- the cycle spacing of strobes around branches;
- undefined opcodes leaving no trace on the ports.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

  localparam int DW = 16;

  // ALU operation codes (low nibble of ALU opcodes)
  localparam logic [3:0] ALU_ADD = 4'd0;
  localparam logic [3:0] ALU_SUB = 4'd1;
  localparam logic [3:0] ALU_AND = 4'd2;
  localparam logic [3:0] ALU_OR  = 4'd3;
  localparam logic [3:0] ALU_XOR = 4'd4;
  localparam logic [3:0] ALU_LD  = 4'd5;
  localparam logic [3:0] ALU_SHR = 4'd6;

  // Branch condition kinds (opcode bits 9:8)
  localparam logic [1:0] BRK_ALWAYS = 2'd0;
  localparam logic [1:0] BRK_ZERO   = 2'd1;
  localparam logic [1:0] BRK_NZERO  = 2'd2;
  localparam logic [1:0] BRK_NEG    = 2'd3;

  localparam logic [7:0] OPC_LDX = 8'h61;

  typedef struct packed {
    logic       vld;
    logic       alu_en;
    logic [3:0] alu_op;
    logic       use_mem;
    logic       st;
    logic       stx;
    logic       ldar;
    logic       io_in;
    logic       io_out;
    logic       br;
    logic [1:0] br_kind;
    logic [7:0] arg;
  } ex_ctl_t;

  function automatic logic [DW-1:0] alu_calc(input logic [3:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_XOR: r = a ^ b;
      ALU_LD:  r = b;
      ALU_SHR: r = {1'b0, a[DW-1:1]};
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic br_cond(input logic [1:0] kind, input logic [DW-1:0] a);
    logic t;
    case (kind)
      BRK_ALWAYS: t = 1'b1;
      BRK_ZERO:   t = (a == '0);
      BRK_NZERO:  t = (a != '0);
      default:    t = a[DW-1];
    endcase
    return t;
  endfunction

  function automatic ex_ctl_t decode_word(input logic [15:0] w);
    ex_ctl_t c;
    c = '0;
    c.arg = w[7:0];
    case (w[15:12])
      4'h1, 4'h2: begin
        if (w[11:8] <= ALU_SHR) begin
          c.alu_en  = 1'b1;
          c.alu_op  = w[11:8];
          c.use_mem = (w[15:12] == 4'h2);
        end
      end
      4'h3: c.st = (w[11:8] == 4'h0);
      4'h4: begin
        c.io_out = (w[11:8] == 4'h0);
        c.io_in  = (w[11:8] == 4'h1);
      end
      4'h5: begin
        if (w[11:10] == 2'b00) begin
          c.br      = 1'b1;
          c.br_kind = w[9:8];
        end
      end
      4'h6: begin
        case (w[11:8])
          4'h0: c.ldar = 1'b1;
          4'h1: begin
            c.alu_en  = 1'b1;
            c.alu_op  = ALU_LD;
            c.use_mem = 1'b1;
          end
          4'h2: c.stx = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tacc_fetch.sv
module tacc_fetch #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [PC_W-1:0] prog_addr,
  input  logic [15:0]     prog_data,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_o,
  output logic [15:0]     ir_o,
  output logic            ir_vld_o
);
  localparam int DEPTH = 1 << PC_W;

  logic [15:0]     imem [DEPTH];
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;
  logic [15:0]     ir_q;
  logic            ir_vld_q;

  assign pc_next = redirect ? target : pc_q + 1'b1;

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
    ir_q <= imem[pc_next];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '1;
      ir_vld_q <= 1'b0;
    end else begin
      pc_q     <= pc_next;
      ir_vld_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign ir_vld_o = ir_vld_q;

  // R5: sequential fetch advances by exactly one
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  // R6: a taken branch lands fetch on its target
  assert_pc_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> pc_q == $past(target));

endmodule

// File: rtl/tacc_dmem.sv
module tacc_dmem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [15:0] mem [DEPTH];
  logic [15:0] q;
  logic [15:0] byp_q;
  logic        hit_q;
  logic        same_addr;

  assign same_addr = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q     <= mem[raddr];
    byp_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= same_addr;
  end

  assign rdata = hit_q ? byp_q : q;

  // R4: read directly after a same-address write returns the written word
  assert_store_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    same_addr |=> rdata == $past(wdata));

endmodule

// File: rtl/tacc_exec.sv
module tacc_exec #(
  parameter int PC_W  = 8,
  parameter int DM_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             alu_en,
  input  logic [3:0]       alu_op,
  input  logic             use_mem,
  input  logic             io_in,
  input  logic             ldar,
  input  logic             br,
  input  logic [1:0]       br_kind,
  input  logic [7:0]       arg,
  input  logic [PC_W-1:0]  ex_pc,
  input  logic [15:0]      mem_data,
  input  logic [15:0]      io_rdata,
  output logic [15:0]      acc_o,
  output logic [DM_AW-1:0] ptr_o,
  output logic             br_taken,
  output logic [PC_W-1:0]  br_target
);
  import tacc_pkg::*;

  logic [15:0]      acc_q;
  logic [DM_AW-1:0] ptr_q;
  logic [15:0]      operand;
  logic             acc_wr;

  assign operand   = use_mem ? mem_data : {8'h00, arg};
  assign acc_wr    = vld && (alu_en || io_in);
  assign br_taken  = vld && br && br_cond(br_kind, acc_q);
  assign br_target = ex_pc + PC_W'(signed'(arg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ptr_q <= '0;
    end else if (vld) begin
      if (alu_en)     acc_q <= alu_calc(alu_op, acc_q, operand);
      else if (io_in) acc_q <= io_rdata;
      if (ldar)       ptr_q <= acc_q[DM_AW-1:0];
    end
  end

  assign acc_o = acc_q;
  assign ptr_o = ptr_q;

  // R11: accumulator only changes for an accumulator-writing instruction
  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(acc_q));

endmodule

// File: rtl/tacc_core.sv
module tacc_core #(
  parameter int PC_W  = 8,
  parameter int DM_AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [PC_W-1:0] prog_addr,
  input  logic [15:0]     prog_data,
  output logic [7:0]      io_addr,
  output logic            io_rd,
  output logic            io_wr,
  output logic [15:0]     io_wdata,
  input  logic [15:0]     io_rdata,
  output logic [15:0]     acc_out
);
  import tacc_pkg::*;

  logic [PC_W-1:0]  fetch_pc;
  logic [15:0]      ir;
  logic             ir_vld;
  logic             br_taken;
  logic [PC_W-1:0]  br_target;
  ex_ctl_t          ctl_d;
  ex_ctl_t          ex_q;
  logic [PC_W-1:0]  ex_pc_q;
  logic [15:0]      acc;
  logic [DM_AW-1:0] ptr;
  logic [DM_AW-1:0] ptr_eff;
  logic [DM_AW-1:0] rd_addr;
  logic [DM_AW-1:0] wr_addr;
  logic             dm_we;
  logic [15:0]      dm_rdata;
  logic             ir_ldx;

  tacc_fetch #(.PC_W(PC_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .redirect(br_taken), .target(br_target),
    .pc_o(fetch_pc), .ir_o(ir), .ir_vld_o(ir_vld)
  );

  // Decode: the slot behind a taken branch is cancelled
  always_comb begin
    ctl_d     = decode_word(ir);
    ctl_d.vld = ir_vld && !br_taken;
  end

  // Pointer seen by decode: a pointer update now in execute is forwarded
  assign ptr_eff = (ex_q.vld && ex_q.ldar) ? acc[DM_AW-1:0] : ptr;
  assign ir_ldx  = (ir[15:8] == OPC_LDX);
  assign rd_addr = ir_ldx ? ptr_eff : DM_AW'(ir[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q    <= '0;
      ex_pc_q <= '0;
    end else begin
      ex_q    <= ctl_d;
      ex_pc_q <= fetch_pc;
    end
  end

  assign dm_we   = ex_q.vld && (ex_q.st || ex_q.stx);
  assign wr_addr = ex_q.stx ? ptr : DM_AW'(ex_q.arg);

  tacc_dmem #(.AW(DM_AW)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .we(dm_we), .waddr(wr_addr), .wdata(acc),
    .raddr(rd_addr), .rdata(dm_rdata)
  );

  tacc_exec #(.PC_W(PC_W), .DM_AW(DM_AW)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .vld(ex_q.vld), .alu_en(ex_q.alu_en), .alu_op(ex_q.alu_op),
    .use_mem(ex_q.use_mem), .io_in(ex_q.io_in), .ldar(ex_q.ldar),
    .br(ex_q.br), .br_kind(ex_q.br_kind), .arg(ex_q.arg),
    .ex_pc(ex_pc_q), .mem_data(dm_rdata), .io_rdata(io_rdata),
    .acc_o(acc), .ptr_o(ptr),
    .br_taken(br_taken), .br_target(br_target)
  );

  assign io_wr    = ex_q.vld && ex_q.io_out;
  assign io_rd    = ex_q.vld && ex_q.io_in;
  assign io_addr  = (io_wr || io_rd) ? ex_q.arg : 8'h00;
  assign io_wdata = io_wr ? acc : 16'h0000;
  assign acc_out  = acc;

  // R8: strobes never overlap
  assert_io_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_rd, io_wr}));

  // R6: the instruction behind a taken branch never reaches execute
  assert_flush_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> !ex_q.vld);

  // R1: nothing executes in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_vld) |-> !io_wr && !io_rd);

endmodule

// File: tb/sim_tacc_core.sv
`timescale 1ns/1ps
module sim_tacc_core;
  localparam int PC_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            prog_we = 1'b0;
  logic [PC_W-1:0] prog_addr = '0;
  logic [15:0]     prog_data = '0;
  logic [7:0]      io_addr;
  logic            io_rd, io_wr;
  logic [15:0]     io_wdata, io_rdata, acc_out;

  always #10 clk = ~clk;

  assign io_rdata = {8'hC0, io_addr};

  tacc_core #(.PC_W(PC_W), .DM_AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .acc_out(acc_out)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] prog [64];
  int plen;
  logic [7:0]  ev_a [64];
  logic [15:0] ev_d [64];
  int          ev_c [64];
  int ev_n = 0, rd_n = 0;
  logic [7:0] rd_a;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (io_wr && ev_n < 64) begin
        ev_a[ev_n] = io_addr; ev_d[ev_n] = io_wdata; ev_c[ev_n] = cyc;
        ev_n = ev_n + 1;
      end
      if (io_rd) begin rd_n = rd_n + 1; rd_a = io_addr; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic p(input int i, input logic [7:0] op, input logic [7:0] a);
    prog[i] = {op, a};
    if (i + 1 > plen) plen = i + 1;
  endtask

  task automatic load_run(input int cycles);
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < plen; i++) begin
      prog_we = 1'b1; prog_addr = PC_W'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    ev_n = 0; rd_n = 0;
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic expect_ev(input int idx, input logic [7:0] a, input logic [15:0] d, input string req);
    check(ev_n > idx, req, 16'(ev_n), 16'(idx + 1));
    if (ev_n > idx) begin
      check(ev_a[idx] == a, req, {8'h00, ev_a[idx]}, {8'h00, a});
      check(ev_d[idx] == d, req, ev_d[idx], d);
    end
  endtask

  // R2 and R10: immediate ALU operations and logical right shift
  task automatic t_alu();
    plen = 0;
    p(0, 8'h15, 8'h3C); p(1, 8'h40, 8'h01);
    p(2, 8'h10, 8'h05); p(3, 8'h40, 8'h01);
    p(4, 8'h11, 8'h50); p(5, 8'h40, 8'h01);
    p(6, 8'h12, 8'hF0); p(7, 8'h40, 8'h01);
    p(8, 8'h13, 8'h0F); p(9, 8'h40, 8'h01);
    p(10, 8'h14, 8'h3C); p(11, 8'h40, 8'h01);
    p(12, 8'h16, 8'hAB); p(13, 8'h40, 8'h01);
    p(14, 8'h15, 8'h00); p(15, 8'h11, 8'h02); p(16, 8'h16, 8'h00); p(17, 8'h40, 8'h02);
    p(18, 8'h50, 8'h00);
    load_run(40);
    expect_ev(0, 8'h01, 16'h003C, "R2 ldi");
    expect_ev(1, 8'h01, 16'h003C + 16'h0005, "R2 add");
    expect_ev(2, 8'h01, 16'h0041 - 16'h0050, "R2 sub wrap");
    expect_ev(3, 8'h01, 16'hFFF1 & 16'h00F0, "R2 and");
    expect_ev(4, 8'h01, 16'h00F0 | 16'h000F, "R2 or");
    expect_ev(5, 8'h01, 16'h00FF ^ 16'h003C, "R2 xor");
    expect_ev(6, 8'h01, 16'h00C3 >> 1, "R10 shr");
    expect_ev(7, 8'h02, 16'hFFFE >> 1, "R10 shr zero fill");
  endtask

  // R1: reset state and first instruction timing
  task automatic t_reset();
    int c0;
    check(acc_out != 16'h0, "R1 precondition acc nonzero", acc_out, 16'h0001);
    plen = 0;
    p(0, 8'h40, 8'h07); p(1, 8'h50, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    check(acc_out == 16'h0, "R1 acc in reset", acc_out, 16'h0);
    check(!io_wr && !io_rd, "R1 strobes in reset", {14'h0, io_rd, io_wr}, 16'h0);
    for (int i = 0; i < plen; i++) begin
      prog_we = 1'b1; prog_addr = PC_W'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0; ev_n = 0; rd_n = 0;
    c0 = cyc;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    expect_ev(0, 8'h07, 16'h0000, "R1 first instruction");
    check(ev_c[0] == c0 + 2, "R1 first strobe cycle", 16'(ev_c[0] - c0), 16'd2);
  endtask

  // R3 and R4: register-slot operands, stores and store-to-read bypass
  task automatic t_reg();
    plen = 0;
    p(0, 8'h15, 8'h12); p(1, 8'h30, 8'h05); p(2, 8'h15, 8'h34); p(3, 8'h30, 8'h06);
    p(4, 8'h25, 8'h05); p(5, 8'h40, 8'h01); p(6, 8'h20, 8'h06); p(7, 8'h40, 8'h01);
    p(8, 8'h15, 8'h77); p(9, 8'h30, 8'h09); p(10, 8'h25, 8'h09); p(11, 8'h40, 8'h02);
    p(12, 8'h15, 8'h10); p(13, 8'h30, 8'h09); p(14, 8'h20, 8'h09); p(15, 8'h40, 8'h03);
    p(16, 8'h50, 8'h00);
    load_run(40);
    expect_ev(0, 8'h01, 16'h0012, "R3 load slot");
    expect_ev(1, 8'h01, 16'h0046, "R3 add slot");
    expect_ev(2, 8'h02, 16'h0077, "R4 store then load");
    expect_ev(3, 8'h03, 16'h0020, "R4 store then add");
  endtask

  // R5: one instruction per clock
  task automatic t_timing();
    plen = 0;
    p(0, 8'h15, 8'h09); p(1, 8'h40, 8'h01); p(2, 8'h40, 8'h02); p(3, 8'h40, 8'h03);
    p(4, 8'h50, 8'h00);
    load_run(30);
    check(ev_n == 3, "R5 event count", 16'(ev_n), 16'd3);
    check(ev_c[1] - ev_c[0] == 1, "R5 spacing", 16'(ev_c[1] - ev_c[0]), 16'd1);
    check(ev_c[2] - ev_c[1] == 1, "R5 spacing", 16'(ev_c[2] - ev_c[1]), 16'd1);
  endtask

  // R6: unconditional forward branch, skipped slots, one-cycle penalty
  task automatic t_branch();
    plen = 0;
    p(0, 8'h15, 8'h01); p(1, 8'h40, 8'h01); p(2, 8'h50, 8'h03);
    p(3, 8'h40, 8'hEE); p(4, 8'h40, 8'hEE); p(5, 8'h40, 8'h02); p(6, 8'h50, 8'h00);
    load_run(30);
    check(ev_n == 2, "R6 skipped instructions", 16'(ev_n), 16'd2);
    expect_ev(1, 8'h02, 16'h0001, "R6 branch target");
    check(ev_c[1] - ev_c[0] == 3, "R6 taken penalty", 16'(ev_c[1] - ev_c[0]), 16'd3);
  endtask

  // R7: backward conditional loop
  task automatic t_loop();
    plen = 0;
    p(0, 8'h15, 8'h03); p(1, 8'h40, 8'h04); p(2, 8'h11, 8'h01); p(3, 8'h52, 8'hFE);
    p(4, 8'h40, 8'h05); p(5, 8'h50, 8'h00);
    load_run(40);
    check(ev_n == 4, "R7 loop count", 16'(ev_n), 16'd4);
    expect_ev(0, 8'h04, 16'h0003, "R7 loop iter");
    expect_ev(2, 8'h04, 16'h0001, "R7 loop iter");
    expect_ev(3, 8'h05, 16'h0000, "R7 loop exit");
    check(ev_c[1] - ev_c[0] == 4, "R7 loop period", 16'(ev_c[1] - ev_c[0]), 16'd4);
  endtask

  // R7: zero, nonzero and sign conditions; not-taken costs nothing
  task automatic t_cond();
    plen = 0;
    p(0, 8'h15, 8'h05); p(1, 8'h40, 8'h01); p(2, 8'h51, 8'h03); p(3, 8'h40, 8'h02);
    p(4, 8'h11, 8'h06); p(5, 8'h53, 8'h02); p(6, 8'h40, 8'hEE); p(7, 8'h40, 8'h03);
    p(8, 8'h51, 8'h02); p(9, 8'h40, 8'h04); p(10, 8'h12, 8'h00); p(11, 8'h51, 8'h02);
    p(12, 8'h40, 8'hEE); p(13, 8'h40, 8'h06); p(14, 8'h50, 8'h00);
    load_run(40);
    check(ev_n == 5, "R7 event count", 16'(ev_n), 16'd5);
    expect_ev(1, 8'h02, 16'h0005, "R7 zero not taken");
    check(ev_c[1] - ev_c[0] == 2, "R7 not-taken cost", 16'(ev_c[1] - ev_c[0]), 16'd2);
    expect_ev(2, 8'h03, 16'hFFFF, "R7 negative taken");
    expect_ev(3, 8'h04, 16'hFFFF, "R7 zero not taken on ffff");
    expect_ev(4, 8'h06, 16'h0000, "R7 zero taken");
  endtask

  // R8: input and output instructions
  task automatic t_io();
    plen = 0;
    p(0, 8'h41, 8'h21); p(1, 8'h40, 8'h30); p(2, 8'h50, 8'h00);
    load_run(20);
    check(rd_n == 1, "R8 read strobe count", 16'(rd_n), 16'd1);
    check(rd_a == 8'h21, "R8 read address", {8'h00, rd_a}, 16'h0021);
    check(ev_n == 1, "R8 write strobe count", 16'(ev_n), 16'd1);
    expect_ev(0, 8'h30, 16'hC021, "R8 input data to output");
  endtask

  // R9: pointer register and indirect access
  task automatic t_ptr();
    plen = 0;
    p(0, 8'h15, 8'h40); p(1, 8'h60, 8'h00); p(2, 8'h15, 8'h5A); p(3, 8'h62, 8'h00);
    p(4, 8'h15, 8'h41); p(5, 8'h60, 8'h00); p(6, 8'h15, 8'h66); p(7, 8'h62, 8'h00);
    p(8, 8'h25, 8'h40); p(9, 8'h40, 8'h01); p(10, 8'h25, 8'h41); p(11, 8'h40, 8'h02);
    p(12, 8'h15, 8'h40); p(13, 8'h60, 8'h00); p(14, 8'h61, 8'h00); p(15, 8'h40, 8'h03);
    p(16, 8'h50, 8'h00);
    load_run(40);
    expect_ev(0, 8'h01, 16'h005A, "R9 indirect store");
    expect_ev(1, 8'h02, 16'h0066, "R9 indirect store second");
    expect_ev(2, 8'h03, 16'h005A, "R9 load after pointer update");
  endtask

  // R11: undefined opcodes have no effect
  task automatic t_illegal();
    plen = 0;
    p(0, 8'h15, 8'h07); p(1, 8'hFF, 8'h12); p(2, 8'h17, 8'h01); p(3, 8'h31, 8'h00);
    p(4, 8'h25, 8'h00); p(5, 8'h40, 8'h01); p(6, 8'h50, 8'h00);
    // slot 0 preset to a known value first
    p(7, 8'h00, 8'h00);
    prog[0] = {8'h15, 8'h07};
    load_run(10);
    plen = 0;
    p(0, 8'h15, 8'h99); p(1, 8'h30, 8'h00); p(2, 8'h15, 8'h07); p(3, 8'hFF, 8'h12);
    p(4, 8'h17, 8'h01); p(5, 8'h31, 8'h00); p(6, 8'h40, 8'h01); p(7, 8'h25, 8'h00);
    p(8, 8'h40, 8'h02); p(9, 8'h50, 8'h00);
    load_run(30);
    check(ev_n == 2, "R11 no extra strobes", 16'(ev_n), 16'd2);
    check(rd_n == 0, "R11 no read strobe", 16'(rd_n), 16'd0);
    expect_ev(0, 8'h01, 16'h0007, "R11 acc untouched");
    expect_ev(1, 8'h02, 16'h0099, "R11 memory untouched");
  endtask

  initial begin
    t_alu();
    t_reset();
    t_reg();
    t_timing();
    t_branch();
    t_loop();
    t_cond();
    t_io();
    t_ptr();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule